// File: doc/BRIEF.md
# Remote Timer Request Coalescer

This block sits between a local software or hardware timer queue and a remote timer that is programmed through a slow, single-entry command channel. Each time the earliest local deadline changes, the new absolute target time on the free-running timebase is presented. The block then decides whether the remote timer must be reprogrammed. When it does send a command, it converts the remaining time into a whole number of microseconds, rounded up, and never goes below a fixed minimum delay.

The block keeps the number of commands small. While a command is outstanding, it only records a new target if that target is earlier than the stored one, and it sends that target once the command completes. While a timer is already running, it reprograms the timer only if the new target comes clearly before the running expiry. Between two expiry events it sends at most a fixed number of commands. It also watches the running timer. If the expected expiry is overrun by too long a margin, it raises a sticky fallback flag and stops issuing commands. From then on the caller must time events locally.

Top module: `rtc_coalescer`

## Requirements
- R1: After reset, `cmd_req`, `cmd_busy`, `timer_armed` and `fallback` are all 0.
- R2: When an accepted update arrives with no command outstanding and no timer armed, `cmd_req` pulses on the next clock edge and `cmd_busy` rises with it. `cmd_delay_us` then equals ceil((target − now) / TICKS_PER_US).
- R3: When the target is not more than MIN_US·TICKS_PER_US ticks beyond `now` (including targets already in the past), the issued delay is MIN_US (500).
- R4: An update whose target equals the stored target is ignored and issues no command.
- R5: While a command is outstanding, no new command is issued. An update during that time is stored only if it is earlier than the stored target. When `cmd_done` arrives, the stored earlier target is issued in the same decision.
- R6: When `cmd_done` arrives with `cmd_ok`=1, `timer_armed` rises and the expected expiry becomes now + delay·TICKS_PER_US. When `cmd_ok`=0, the timer is not armed.
- R7: While a timer is armed, a command is issued only if all three hold: the target is earlier than the expected expiry, that expiry is still in the future, and more than MIN_US·TICKS_PER_US ticks remain before it.
- R8: Each issued command increments an update count. Once that count exceeds MAX_UPDATES (2), no command is issued until an `expiry` pulse clears the count.
- R9: If the timer is armed and `now` exceeds the expected expiry by more than STUCK_US·TICKS_PER_US ticks, `fallback` rises and stays high, `timer_armed` drops, and later updates issue no command.
- R10: An `expiry` pulse clears `timer_armed`.
- R11: An `expiry` pulse in the same cycle as an update clears the update count before that update is judged, so the update can issue a command even when the count had reached its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_valid | input | 1 | New target time is presented this cycle |
| tgt_time | input | TB_W | Absolute target time in timebase ticks |
| now | input | TB_W | Current free-running timebase value |
| cmd_done | input | 1 | Outstanding command has completed |
| cmd_ok | input | 1 | Completion status, 1 = timer was programmed |
| expiry | input | 1 | Remote timer expiry event |
| cmd_req | output | 1 | One-cycle pulse: issue a program-timer command |
| cmd_delay_us | output | DLY_W | Delay of the last issued command, in microseconds |
| cmd_busy | output | 1 | A command is outstanding |
| timer_armed | output | 1 | A programmed timer is believed to be running |
| fallback | output | 1 | Remote timer declared stuck; facility disabled |

## Verification
The case of interest is an expiry pulse that arrives in the same cycle as a target update, at a moment when the update count has already hit its limit. The bench first drives three commands without any expiry and confirms that a fourth update is refused. It then presents expiry and a fresh target on the same cycle. It judges the result by whether `cmd_req` pulses one edge later with the correctly rounded delay. The random phase applies every update together with an expiry pulse, so this overlap is exercised again across hundreds of target and timebase combinations.

// File: rtl/rtc_coalescer.sv
`timescale 1ns/1ps
module rtc_coalescer #(
  parameter int TB_W         = 48,
  parameter int DLY_W        = 24,
  parameter int TICKS_PER_US = 4,
  parameter int MIN_US       = 500,
  parameter int STUCK_US     = 10000,
  parameter int MAX_UPDATES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_valid,
  input  logic [TB_W-1:0]  tgt_time,
  input  logic [TB_W-1:0]  now,
  input  logic             cmd_done,
  input  logic             cmd_ok,
  input  logic             expiry,
  output logic             cmd_req,
  output logic [DLY_W-1:0] cmd_delay_us,
  output logic             cmd_busy,
  output logic             timer_armed,
  output logic             fallback
);
  localparam int CNT_W = $clog2(MAX_UPDATES + 2);
  localparam logic [TB_W-1:0]  TPU_T   = TB_W'(TICKS_PER_US);
  localparam logic [TB_W-1:0]  MIN_T   = TB_W'(MIN_US * TICKS_PER_US);
  localparam logic [TB_W-1:0]  STUCK_T = TB_W'(STUCK_US * TICKS_PER_US);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_UPDATES);

  logic [TB_W-1:0]  target_q, expect_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             pend_q, busy_q, armed_q, fb_q, req_q;

  wire en      = !fb_q;
  wire upd     = tgt_valid && en && (tgt_time != target_q);
  wire hold    = busy_q || pend_q;
  wire earlier = tgt_time < target_q;
  wire [TB_W-1:0] tgt_nx = (upd && (!hold || earlier)) ? tgt_time : target_q;
  wire pend_nx = pend_q || (upd && hold && earlier);
  wire done    = cmd_done && busy_q;
  wire done_ok = done && cmd_ok && en;

  wire [TB_W-1:0] prog_ticks = TB_W'(dly_q) * TPU_T;
  wire [TB_W-1:0] exp_eff    = done_ok ? now + prog_ticks : expect_q;
  wire            armed_eff  = done_ok || (armed_q && !expiry);
  wire [CNT_W-1:0] cnt_eff   = expiry ? '0 : cnt_q;

  wire late  = armed_q && (now > expect_q) && ((now - expect_q) > STUCK_T);
  wire stuck = en && late && !expiry && !done_ok;

  wire try_send = en && !stuck && ((upd && !hold) || (done && pend_nx));
  wire gated    = armed_eff && ((tgt_nx >= exp_eff) || (now >= exp_eff) ||
                                ((exp_eff - now) <= MIN_T));
  wire limited  = cnt_eff > CNT_MAX;
  wire fire     = try_send && !gated && !limited;

  wire [TB_W-1:0]  diff     = tgt_nx - now;
  wire [DLY_W-1:0] delay_nx = ((tgt_nx > now) && (diff > MIN_T)) ?
                              DLY_W'((diff + TPU_T - TB_W'(1)) / TPU_T) :
                              DLY_W'(MIN_US);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q <= '0;
      expect_q <= '1;
      cnt_q    <= '0;
      dly_q    <= '0;
      pend_q   <= 1'b0;
      busy_q   <= 1'b0;
      armed_q  <= 1'b0;
      fb_q     <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      req_q    <= fire;
      target_q <= tgt_nx;
      pend_q   <= done ? 1'b0 : pend_nx;
      busy_q   <= fire ? 1'b1 : (done ? 1'b0 : busy_q);
      armed_q  <= stuck ? 1'b0 : armed_eff;
      cnt_q    <= fire ? cnt_eff + CNT_W'(1) : cnt_eff;
      if (done_ok) expect_q <= exp_eff;
      if (fire)    dly_q    <= delay_nx;
      if (stuck)   fb_q     <= 1'b1;
    end
  end

  assign cmd_req      = req_q;
  assign cmd_delay_us = dly_q;
  assign cmd_busy     = busy_q;
  assign timer_armed  = armed_q;
  assign fallback     = fb_q;
endmodule

// File: rtl/rtc_coalescer_chk.sv
`timescale 1ns/1ps
module rtc_coalescer_chk #(
  parameter int MAX_UPDATES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic expiry,
  input logic cmd_done,
  input logic cmd_ok,
  input logic cmd_req,
  input logic cmd_busy,
  input logic timer_armed,
  input logic fallback
);
  logic [7:0] sent_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) sent_cnt <= '0;
    else if (expiry) sent_cnt <= '0;
    else if (cmd_req && sent_cnt != 8'hff) sent_cnt <= sent_cnt + 8'd1;
  end

  a_r2_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> cmd_busy);
  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !cmd_done) |=> !cmd_req);
  a_r6_arm_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    (!fallback && cmd_busy && cmd_done && cmd_ok) |=> timer_armed);
  a_r8_rate_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (sent_cnt <= 8'(MAX_UPDATES)));
  a_r9_fallback_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |=> fallback);
  a_r9_silent_in_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |-> !cmd_req);
  a_r9_disarm_on_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback) |-> !timer_armed);
  a_r10_expiry_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry && !(cmd_busy && cmd_done && cmd_ok)) |=> !timer_armed);
endmodule

bind rtc_coalescer rtc_coalescer_chk #(.MAX_UPDATES(MAX_UPDATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .expiry(expiry), .cmd_done(cmd_done),
  .cmd_ok(cmd_ok), .cmd_req(cmd_req), .cmd_busy(cmd_busy),
  .timer_armed(timer_armed), .fallback(fallback)
);

// File: tb/test_rtc_coalescer.sv
`timescale 1ns/1ps
module test_rtc_coalescer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tgt_valid = 1'b0;
  logic [47:0] tgt_time = '0;
  logic [47:0] now = '0;
  logic        cmd_done = 1'b0;
  logic        cmd_ok = 1'b0;
  logic        expiry = 1'b0;
  logic        cmd_req;
  logic [23:0] cmd_delay_us;
  logic        cmd_busy;
  logic        timer_armed;
  logic        fallback;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rtc_coalescer i_rtc_coalescer (
    .clk(clk), .rst_n(rst_n), .tgt_valid(tgt_valid), .tgt_time(tgt_time),
    .now(now), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .expiry(expiry),
    .cmd_req(cmd_req), .cmd_delay_us(cmd_delay_us), .cmd_busy(cmd_busy),
    .timer_armed(timer_armed), .fallback(fallback)
  );

  function automatic logic [23:0] want_dly(input logic [47:0] t, input logic [47:0] n);
    logic [47:0] d;
    if (t > n && (t - n) > 48'd2000) begin
      d = (t - n + 48'd3) / 48'd4;
      return d[23:0];
    end
    return 24'd500;
  endfunction

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic upd(input logic [47:0] t);
    tgt_valid = 1'b1; tgt_time = t;
    tick;
    tgt_valid = 1'b0;
  endtask

  task automatic finish_cmd(input logic ok);
    cmd_done = 1'b1; cmd_ok = ok;
    tick;
    cmd_done = 1'b0; cmd_ok = 1'b0;
  endtask

  task automatic fire_expiry;
    expiry = 1'b1;
    tick;
    expiry = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] last_t;
    do_reset;
    // R1 reset state
    chk("R1 cmd_req", 48'(cmd_req), 0);
    chk("R1 cmd_busy", 48'(cmd_busy), 0);
    chk("R1 timer_armed", 48'(timer_armed), 0);
    chk("R1 fallback", 48'(fallback), 0);

    // R2 idle update
    now = 48'd1000;
    upd(48'd9001);
    chk("R2 req", 48'(cmd_req), 1);
    chk("R2 delay", 48'(cmd_delay_us), 48'(want_dly(48'd9001, 48'd1000)));
    chk("R2 busy", 48'(cmd_busy), 1);

    // R5 updates while outstanding
    upd(48'd20000);
    chk("R5 later ignored", 48'(cmd_req), 0);
    upd(48'd5000);
    chk("R5 earlier held", 48'(cmd_req), 0);
    finish_cmd(1'b1);
    chk("R5 pending issued", 48'(cmd_req), 1);
    chk("R5 pending delay", 48'(cmd_delay_us), 1000);
    chk("R6 armed", 48'(timer_armed), 1);
    finish_cmd(1'b1);          // expected expiry 1000 + 4000 = 5000
    chk("R6 idle after done", 48'(cmd_busy), 0);

    // R7 gating against in-flight expiry
    upd(48'd6000);
    chk("R7 later than expiry", 48'(cmd_req), 0);
    upd(48'd3000);
    chk("R7 earlier accepted", 48'(cmd_req), 1);
    chk("R3 minimum delay", 48'(cmd_delay_us), 500);
    finish_cmd(1'b1);          // expected expiry 3000, count 3
    upd(48'd2500);
    chk("R7 margin not exceeded", 48'(cmd_req), 0);

    // R8 rate limit with now moved back so only the count blocks
    now = 48'd0;
    upd(48'd2400);
    chk("R8 limited", 48'(cmd_req), 0);
    fire_expiry;
    chk("R10 expiry disarms", 48'(timer_armed), 0);
    upd(48'd2400);
    chk("R4 equal ignored", 48'(cmd_req), 0);
    upd(48'd2600);
    chk("R8 count cleared", 48'(cmd_req), 1);
    chk("R8 delay", 48'(cmd_delay_us), 650);
    finish_cmd(1'b0);
    chk("R6 failed not armed", 48'(timer_armed), 0);
    upd(48'd10000);
    chk("R2 delay 2", 48'(cmd_delay_us), 2500);
    finish_cmd(1'b0);
    upd(48'd9000);
    chk("R2 delay 3", 48'(cmd_delay_us), 2250);
    finish_cmd(1'b0);
    upd(48'd8000);
    chk("R8 fourth refused", 48'(cmd_req), 0);

    // R11 expiry and update in the same cycle
    expiry = 1'b1;
    upd(48'd7000);
    expiry = 1'b0;
    chk("R11 issued", 48'(cmd_req), 1);
    chk("R11 delay", 48'(cmd_delay_us), 1750);
    finish_cmd(1'b1);          // expected expiry 7000

    // R9 stuck detection
    now = 48'd47000;
    tick;
    chk("R9 at margin", 48'(fallback), 0);
    now = 48'd47001;
    tick;
    chk("R9 fallback", 48'(fallback), 1);
    chk("R9 disarmed", 48'(timer_armed), 0);
    fire_expiry;
    upd(48'd100000);
    chk("R9 silent", 48'(cmd_req), 0);

    // random phase: R2, R3, R11
    do_reset;
    last_t = '0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [47:0] n, t;
      int off;
      n = 48'(32'd10000 + ($urandom % 32'd1000000));
      off = int'($urandom % 32'd20000) - 5000;
      t = (off >= 0) ? n + 48'(off) : n - 48'(-off);
      if (t == last_t) continue;
      now = n;
      expiry = 1'b1;
      upd(t);
      expiry = 1'b0;
      chk("R11 random req", 48'(cmd_req), 1);
      chk((t > n && t - n > 2000) ? "R2 random delay" : "R3 random delay",
          48'(cmd_delay_us), 48'(want_dly(t, n)));
      finish_cmd(1'b0);
      last_t = t;
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule